// File: doc/BRIEF.md
# Windowed Loss-of-Lock Monitor

This block watches a clock recovery loop that has already locked and reports when it seems to have slipped. It runs in the parallel (word) clock domain. An upstream sampler reports, every parallel cycle, how many data transitions fell inside the forbidden sampling zone. The monitor adds these counts over fixed windows of parallel cycles. When the running total in the current window reaches a programmable threshold, it raises a lock-lost flag.

The flag is not sticky. Once raised, it stays high until the current window closes. At the window boundary the flag drops and the running total restarts from zero. An enable input keeps the whole monitor at rest until the surrounding logic has declared the initial lock. Raising the enable starts a fresh window.

Top module: `lock_loss_monitor`

## Requirements
- R1: While `mon_en` is low, `lock_lost` is low in the following cycle and the monitor is at rest. The first cycle with `mon_en` high is cycle 1 of a new window.
- R2: `slip_cnt` is an unsigned 2-bit count of 0 to 3 errors for the present cycle. The whole count is added to the window total.
- R3: In cycles 1 to 63 of a window, if the total including the present cycle's count is greater than or equal to a nonzero `slip_limit`, then `lock_lost` is high from the next cycle. The comparison uses the value of `slip_limit` in that same cycle.
- R4: Once `lock_lost` is high, it stays high through the rest of the current window, whatever the later inputs are.
- R5: A window is 64 parallel cycles long. After cycle 64, `lock_lost` is low and the total is zero. The count that arrives in cycle 64 is discarded and never raises the flag.
- R6: A `slip_limit` of zero never raises `lock_lost`.
- R7: The window total saturates at 63 and does not wrap. A large total therefore still meets a limit that is raised later in the same window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | High once initial lock is declared; low holds the monitor at rest |
| slip_cnt | input | 2 | Sampling errors seen in this parallel cycle |
| slip_limit | input | 6 | Error total that signals loss of lock; 0 turns detection off |
| lock_lost | output | 1 | Loss-of-lock flag, cleared at each window boundary |

## Verification
The assertions take `slip_cnt` to be a clean per-cycle count with no meaning of its own while `mon_en` is low. They also allow `slip_limit` to change in any cycle, so they only relate a rise of the flag to the limit seen one cycle earlier. The stimulus changes every input at the falling clock edge only. It covers all three nonzero error rates against limits from 1 to 63, and it crosses windows several times. It also raises the limit in the middle of a window over a total that has saturated, to show that the total did not wrap.

// File: rtl/lock_mon_pkg.sv
package lock_mon_pkg;

  // Add with a ceiling so the window total never wraps.
  function automatic int unsigned sat_add(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned cap);
    int unsigned s;
    s = a + b;
    return (s > cap) ? cap : s;
  endfunction

  // Loss-of-lock test: a zero limit disables detection.
  function automatic logic limit_met(input int unsigned total,
                                     input int unsigned limit);
    return (limit != 0) && (total >= limit);
  endfunction

endpackage

// File: rtl/llm_win_timer.sv
module llm_win_timer #(
  parameter int WIN_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic win_last
);
  localparam int POS_W = $clog2(WIN_LEN);

  logic [POS_W-1:0] pos_q;

  assign win_last = (pos_q == POS_W'(WIN_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pos_q <= '0;
    else if (!en || win_last)   pos_q <= '0;
    else                        pos_q <= pos_q + 1'b1;
  end

  // R5: position advances one per enabled cycle inside a window
  p_pos_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en && !win_last |=> pos_q == $past(pos_q) + 1'b1);

  // R5: window restarts after its last cycle
  p_pos_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en && win_last |=> pos_q == '0);

  // R1: disabled monitor starts the next window from the first cycle
  p_pos_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pos_q == '0);
endmodule

// File: rtl/llm_err_accum.sv
module llm_err_accum #(
  parameter int ERR_W = 2,
  parameter int ACC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             win_last,
  input  logic [ERR_W-1:0] err_cnt,
  output logic [ACC_W-1:0] sum_now
);
  localparam int unsigned CAP = (1 << ACC_W) - 1;

  logic [ACC_W-1:0] acc_q;

  assign sum_now = ACC_W'(lock_mon_pkg::sat_add(32'(acc_q), 32'(err_cnt), CAP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 acc_q <= '0;
    else if (!en || win_last)   acc_q <= '0;
    else                        acc_q <= sum_now;
  end

  // R7: inside a window the total never falls (no wrap)
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en && !win_last |=> acc_q >= $past(acc_q));

  // R5: total is zero at the start of each window
  p_acc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_last || !en |=> acc_q == '0);

  // R2: combined total never below the running total
  p_sum_ge_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sum_now >= acc_q);
endmodule

// File: rtl/llm_flag_reg.sv
module llm_flag_reg #(
  parameter int ACC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             win_last,
  input  logic [ACC_W-1:0] sum_now,
  input  logic [ACC_W-1:0] limit,
  output logic             flag
);
  logic hit;

  assign hit = lock_mon_pkg::limit_met(32'(sum_now), 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag <= 1'b0;
    else if (!en || win_last)   flag <= 1'b0;
    else if (hit)               flag <= 1'b1;
  end

  // R5: flag is low after every window boundary
  p_win_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> !flag);

  // R4: flag holds for the rest of the window
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en && flag && !win_last |=> flag);

  // R6: a rise always follows a nonzero limit
  p_zero_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(limit) != '0);

  // R1: disabled monitor keeps the flag low
  p_rest_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !flag);

  // R3: a rise always follows a total at or above the limit
  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(sum_now) >= $past(limit));
endmodule

// File: rtl/lock_loss_monitor.sv
module lock_loss_monitor #(
  parameter int WIN_LEN = 64,
  parameter int ERR_W   = 2,
  parameter int ACC_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_en,
  input  logic [ERR_W-1:0] slip_cnt,
  input  logic [ACC_W-1:0] slip_limit,
  output logic             lock_lost
);
  logic             win_last;
  logic [ACC_W-1:0] sum_now;

  llm_win_timer #(.WIN_LEN(WIN_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(mon_en), .win_last(win_last)
  );

  llm_err_accum #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .en(mon_en), .win_last(win_last),
    .err_cnt(slip_cnt), .sum_now(sum_now)
  );

  llm_flag_reg #(.ACC_W(ACC_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .en(mon_en), .win_last(win_last),
    .sum_now(sum_now), .limit(slip_limit), .flag(lock_lost)
  );
endmodule

// File: tb/lock_loss_monitor_bench.sv
module lock_loss_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mon_en = 1'b0;
  logic [1:0] slip_cnt = '0;
  logic [5:0] slip_limit = '0;
  logic       lock_lost;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench-side model state
  int m_pos = 0;
  int m_total = 0;
  bit m_flag = 0;

  always #5 clk = ~clk;

  lock_loss_monitor u_lock_loss_monitor (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .slip_cnt(slip_cnt),
    .slip_limit(slip_limit), .lock_lost(lock_lost)
  );

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: lock_lost=%0b expected=%0b at pos %0d", req, act, exp, m_pos);
    end
  endtask

  // One parallel cycle: drive at the falling edge, check at the next falling edge.
  task automatic step(input bit en_v, input int e, input int lim, input string req);
    int capped;
    mon_en = en_v;
    slip_cnt = 2'(e);
    slip_limit = 6'(lim);
    if (!en_v) begin
      m_pos = 0; m_total = 0; m_flag = 0;
    end else begin
      m_total += e;
      if (m_pos == 63) begin
        m_pos = 0; m_total = 0; m_flag = 0;
      end else begin
        capped = (m_total > 63) ? 63 : m_total;
        if (lim != 0 && capped >= lim) m_flag = 1;
        m_pos++;
      end
    end
    @(negedge clk);
    check(lock_lost, m_flag, req);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  initial begin
    int lims[5] = '{1, 2, 5, 17, 63};
    @(negedge clk);
    check(lock_lost, 1'b0, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(lock_lost, 1'b0, "R1 after reset");

    // R1: errors while disabled are ignored
    for (int i = 0; i < 20; i++) step(0, 3, 1, "R1 disabled");

    // R2 R3 R4 R5: sweep error rates against limits, two windows each
    foreach (lims[k]) begin
      for (int e = 1; e <= 3; e++) begin
        step(0, 0, lims[k], "R1 restart");
        for (int i = 0; i < 128; i++) step(1, e, lims[k], "R3 R4 R5 sweep");
      end
    end

    // R6: zero limit under heavy errors
    step(0, 0, 0, "R1 restart");
    for (int i = 0; i < 70; i++) step(1, 3, 0, "R6 zero limit");

    // R5: errors in the last window cycle are discarded
    step(0, 0, 1, "R1 restart");
    for (int i = 0; i < 63; i++) step(1, 0, 1, "R5 quiet");
    step(1, 3, 1, "R5 last cycle");
    for (int i = 0; i < 20; i++) step(1, 0, 1, "R5 no carry");

    // R2 R3: sparse single errors
    step(0, 0, 2, "R1 restart");
    for (int i = 0; i < 64; i++) step(1, (i == 10 || i == 40) ? 1 : 0, 2, "R3 sparse");

    // R7: saturated total meets a limit raised later
    step(0, 0, 0, "R1 restart");
    for (int i = 0; i < 40; i++) step(1, 3, 0, "R7 build");
    step(1, 0, 60, "R7 saturate");
    for (int i = 0; i < 30; i++) step(1, 0, 60, "R4 hold");

    // R1: dropping enable mid-window clears and restarts the window
    step(0, 0, 4, "R1 restart");
    for (int i = 0; i < 20; i++) step(1, 1, 4, "R3 rate one");
    step(0, 0, 4, "R1 drop");
    for (int i = 0; i < 62; i++) step(1, 0, 1, "R1 fresh window");
    step(1, 1, 1, "R1 pos 62 hit");
    step(1, 0, 1, "R5 boundary");
    step(1, 0, 1, "R5 next window");

    done = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule